// File: doc/BRIEF.md
# Serial configuration boot sequencer

This block configures a converter's programmable post-filter after power-up. Three strap inputs pick where the filter coefficients come from. In one mode they are streamed from an external serial EPROM. In another they are copied from an internal default set. In the remaining two modes (parallel host and DSP-driven serial) no automatic boot takes place. Each 16-bit word that arrives is written to a coefficient memory port at an incrementing address. The whole frame is checked, and the block then raises a completion flag or holds an error flag.

The load is paced by a serial clock output at one sixteenth of the input clock. Each bit is taken as that clock rises. Once the load succeeds, the same output switches to the run-mode rate: the input clock itself, or half of it. A failed load leaves the block waiting. A low pulse on the reconfigure input then starts the whole sequence again. The completion flag is meant to drive the converter's start-conversion input.

Top module: `cfg_boot_seq`

## Requirements
- R1: Straps decode as {strap_par, strap_m1, strap_m0}. 0xx selects parallel mode, 100 selects the internal default set, 101 selects DSP serial mode, and 110 or 111 selects the external EPROM. In parallel and DSP modes no load runs: ser_en_n stays 1, cfg_done stays 0, err_n stays 1 and coef_we never pulses.
- R2: In EPROM mode ser_en_n is 0 for the whole load, from the cycle after reset or restart. It is 1 once the load has ended, whether the load passed or failed.
- R3: During a load ser_clk has a period of 16 clk_in cycles. A data bit is taken from ser_din as ser_clk rises. Bits arrive MSB first.
- R4: The frame has three parts. First a header word, whose upper byte must be 8'h5A and whose lower byte must equal the expected length (prog_len in EPROM mode). Then that many coefficient words, each written with a one-cycle coef_we at addresses 0, 1, 2 and so on in order. Last a checksum word, which must equal the 16-bit sum of every earlier word, header included.
- R5: After a frame that passes every check, cfg_done goes to 1 and err_n stays 1. Both hold until reset or reconfigure.
- R6: A wrong header tag, a wrong length or a wrong checksum drives err_n to 0 and keeps cfg_done at 0. Both hold while reconf_n stays 1.
- R7: reconf_n sampled low returns the block to strap decode. The load then restarts from the first word, and ser_en_n goes low again in EPROM mode.
- R8: While cfg_done is 1, ser_clk equals clk_in when rate_sel is 0, and has a period of two clk_in cycles when rate_sel is 1.
- R9: In internal mode, ROM_LEN (default 8) words are loaded. Word i is (i*16'h1F3D + 16'h0101) mod 2^16, written at address i. ser_din is ignored and ser_en_n stays 1. ser_clk still runs at the 16-cycle period during the load.
- R10: While rst_n is low, cfg_done is 0, err_n is 1, ser_en_n is 1 and coef_we is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| strap_par | input | 1 | Strap: 0 selects parallel host mode |
| strap_m1 | input | 1 | Serial mode strap, upper bit |
| strap_m0 | input | 1 | Serial mode strap, lower bit |
| reconf_n | input | 1 | Restart the configuration, active low |
| rate_sel | input | 1 | Run-mode clock: 0 gives clk_in, 1 gives clk_in/2 |
| prog_len | input | ADDR_W | Expected coefficient count for the EPROM load |
| ser_din | input | 1 | Serial data from the EPROM |
| ser_en_n | output | 1 | EPROM enable and address reset, active low |
| ser_clk | output | 1 | Serial clock output |
| coef_we | output | 1 | Coefficient memory write strobe |
| coef_addr | output | ADDR_W | Coefficient memory address |
| coef_data | output | WORD_W | Coefficient memory write data |
| cfg_done | output | 1 | Configuration completed successfully |
| err_n | output | 1 | Configuration error, active low |

## Verification
A wrong bit or word counter shows up at the ports as misplaced or corrupted coefficient writes, one word time (256 clocks) after the fault. It also flips the checksum verdict at the end of the frame. A wrong state decode shows as one of three faults: ser_en_n at the wrong level, a serial clock period other than 16, 2 or 1 cycles, or completion and error flags that appear, vanish or never settle. The bench plays each boot mode and each kind of corruption against a serial EPROM model. It compares every written word with a value it computes itself, and it times the serial clock edges in each phase.

// File: rtl/cfg_boot_seq.sv
`timescale 1ns/1ps
module cfg_boot_seq #(
  parameter int WORD_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int DIV_LOG = 4,
  parameter int ROM_LEN = 8,
  parameter int HDR_TAG = 'h5A,
  parameter int ROM_MUL = 'h1F3D,
  parameter int ROM_ADD = 'h0101
) (
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic              strap_par,
  input  logic              strap_m1,
  input  logic              strap_m0,
  input  logic              reconf_n,
  input  logic              rate_sel,
  input  logic [ADDR_W-1:0] prog_len,
  input  logic              ser_din,
  output logic              ser_en_n,
  output logic              ser_clk,
  output logic              coef_we,
  output logic [ADDR_W-1:0] coef_addr,
  output logic [WORD_W-1:0] coef_data,
  output logic              cfg_done,
  output logic              err_n
);
  localparam int BIT_W    = $clog2(WORD_W);
  localparam int TAG_W    = WORD_W - ADDR_W;
  localparam int DIV_HALF = 2 ** (DIV_LOG - 1);

  typedef enum logic [2:0] {ST_DECODE, ST_LOAD, ST_DONE, ST_FAIL, ST_IDLE} state_t;

  state_t             state;
  logic               use_rom;
  logic               half_q;
  logic [DIV_LOG-1:0] div_cnt;
  logic [BIT_W-1:0]   bit_cnt;
  logic [ADDR_W:0]    word_idx;
  logic [WORD_W-1:0]  shreg;
  logic [WORD_W-1:0]  sum_acc;

  logic [ADDR_W-1:0]  exp_len;
  logic [WORD_W-1:0]  hdr_word;
  logic [WORD_W-1:0]  rom_idx;
  logic [WORD_W-1:0]  rom_word;
  logic [WORD_W-1:0]  word_in;
  logic               src_bit;
  logic               sample;
  logic               last_bit;
  logic               is_hdr;
  logic               is_sum;

  assign exp_len  = use_rom ? ADDR_W'(ROM_LEN) : prog_len;
  assign hdr_word = {TAG_W'(HDR_TAG), exp_len};
  assign rom_idx  = WORD_W'(word_idx - 1'b1);
  assign is_hdr   = (word_idx == '0);
  assign is_sum   = (word_idx == {1'b0, exp_len} + 1'b1);

  always_comb begin
    if (is_hdr)      rom_word = hdr_word;
    else if (is_sum) rom_word = sum_acc;
    else             rom_word = rom_idx * WORD_W'(ROM_MUL) + WORD_W'(ROM_ADD);
  end

  assign src_bit  = use_rom ? rom_word[BIT_W'(WORD_W-1) - bit_cnt] : ser_din;
  assign sample   = (state == ST_LOAD) && (div_cnt == DIV_LOG'(DIV_HALF - 1));
  assign last_bit = (bit_cnt == BIT_W'(WORD_W - 1));
  assign word_in  = {shreg[WORD_W-2:0], src_bit};

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_DECODE;
      use_rom   <= 1'b0;
      half_q    <= 1'b0;
      div_cnt   <= '0;
      bit_cnt   <= '0;
      word_idx  <= '0;
      shreg     <= '0;
      sum_acc   <= '0;
      coef_we   <= 1'b0;
      coef_addr <= '0;
      coef_data <= '0;
    end else begin
      coef_we <= 1'b0;
      if (!reconf_n) begin
        state    <= ST_DECODE;
        half_q   <= 1'b0;
        div_cnt  <= '0;
        bit_cnt  <= '0;
        word_idx <= '0;
        sum_acc  <= '0;
      end else begin
        case (state)
          ST_DECODE: begin
            div_cnt  <= '0;
            bit_cnt  <= '0;
            word_idx <= '0;
            sum_acc  <= '0;
            if (!strap_par)    state <= ST_IDLE;
            else if (strap_m1) begin use_rom <= 1'b0; state <= ST_LOAD; end
            else if (strap_m0) state <= ST_IDLE;
            else               begin use_rom <= 1'b1; state <= ST_LOAD; end
          end
          ST_LOAD: begin
            div_cnt <= div_cnt + 1'b1;
            if (sample) begin
              shreg   <= word_in;
              bit_cnt <= bit_cnt + 1'b1;
              if (last_bit) begin
                word_idx <= word_idx + 1'b1;
                if (is_hdr) begin
                  sum_acc <= word_in;
                  if (word_in != hdr_word) state <= ST_FAIL;
                end else if (is_sum) begin
                  state <= (word_in == sum_acc) ? ST_DONE : ST_FAIL;
                end else begin
                  sum_acc   <= sum_acc + word_in;
                  coef_we   <= 1'b1;
                  coef_addr <= ADDR_W'(word_idx - 1'b1);
                  coef_data <= word_in;
                end
              end
            end
          end
          ST_DONE: half_q <= ~half_q;
          default: ;
        endcase
      end
    end
  end

  assign ser_en_n = !((state == ST_LOAD) && !use_rom);
  assign cfg_done = (state == ST_DONE);
  assign err_n    = (state != ST_FAIL);
  assign ser_clk  = (state == ST_DONE) ? (rate_sel ? half_q : clk_in)
                  : (state == ST_LOAD) ? div_cnt[DIV_LOG-1] : 1'b0;

  AST_DONE_ERR_EXCL: assert property (@(posedge clk_in) disable iff (!rst_n)
    !(cfg_done && !err_n)); // R6
  AST_WE_IN_LOAD: assert property (@(posedge clk_in) disable iff (!rst_n)
    coef_we |-> (!cfg_done && err_n)); // R4
  AST_FAIL_STICKY: assert property (@(posedge clk_in) disable iff (!rst_n)
    (!err_n && reconf_n) |=> !err_n); // R6
  AST_DONE_STICKY: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cfg_done && reconf_n) |=> cfg_done); // R5
  AST_RECONF_CLEARS: assert property (@(posedge clk_in) disable iff (!rst_n)
    !reconf_n |=> (!cfg_done && err_n && ser_en_n)); // R7
  AST_EN_NOT_DONE: assert property (@(posedge clk_in) disable iff (!rst_n)
    !ser_en_n |-> (!cfg_done && err_n)); // R2
endmodule

// File: tb/cfg_boot_seq_bench.sv
`timescale 1ns/1ps
module cfg_boot_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic strap_par = 1'b1, strap_m1 = 1'b1, strap_m0 = 1'b0;
  logic reconf_n = 1'b1, rate_sel = 1'b0, noise = 1'b0;
  logic [7:0] prog_len = 8'd6;
  logic ser_din;
  logic ser_en_n, ser_clk, coef_we, cfg_done, err_n;
  logic [7:0] coef_addr;
  logic [15:0] coef_data;
  logic [1:0] corrupt = 2'd0;
  int ptr = 0, wr_cnt = 0, errors = 0, checks = 0;
  logic [15:0] mem [256];

  always #10 clk = ~clk;

  cfg_boot_seq u_cfg_boot_seq (
    .clk_in(clk), .rst_n(rst_n), .strap_par(strap_par), .strap_m1(strap_m1),
    .strap_m0(strap_m0), .reconf_n(reconf_n), .rate_sel(rate_sel),
    .prog_len(prog_len), .ser_din(ser_din), .ser_en_n(ser_en_n),
    .ser_clk(ser_clk), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .cfg_done(cfg_done), .err_n(err_n));

  function automatic logic [15:0] e_word(int i);
    return 16'(16'h4000 + i * 16'h0123);
  endfunction
  function automatic logic [15:0] r_word(int i);
    return 16'(i * 16'h1F3D + 16'h0101);
  endfunction
  function automatic logic [15:0] img(int k, logic [7:0] len, logic [1:0] c);
    logic [15:0] hdr, s;
    hdr = {(c == 2'd1) ? 8'hA5 : 8'h5A, (c == 2'd2) ? 8'(len + 1) : len};
    if (k == 0) return hdr;
    if (k <= int'(len)) return e_word(k - 1);
    s = hdr;
    for (int j = 0; j < int'(len); j++) s = s + e_word(j);
    return (c == 2'd3) ? 16'(s + 1) : s;
  endfunction

  logic img_bit;
  always_comb begin
    logic [15:0] w;
    w = img(ptr / 16, prog_len, corrupt);
    img_bit = w[15 - (ptr % 16)];
  end
  assign ser_din = ser_en_n ? noise : img_bit;

  always @(negedge clk) noise <= ~noise;
  always @(ser_en_n) if (ser_en_n) ptr = 0;
  always @(posedge ser_clk) if (!ser_en_n) begin #1; ptr = ptr + 1; end
  always @(negedge clk) if (coef_we) begin mem[coef_addr] = coef_data; wr_cnt++; end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_cnt = 0;
    cycles(3);
    rst_n = 1'b1;
  endtask

  task automatic period(output longint p);
    longint t0;
    @(posedge ser_clk); t0 = $time;
    @(posedge ser_clk); p = $time - t0;
  endtask

  // {straps[23:21], corrupt[20:19], len[18:11], done[10], err_n[9], rom[8], writes[7:0]}
  localparam logic [23:0] VEC [9] = '{
    {3'b110, 2'd0, 8'd6, 1'b1, 1'b1, 1'b0, 8'd6},
    {3'b111, 2'd0, 8'd3, 1'b1, 1'b1, 1'b0, 8'd3},
    {3'b110, 2'd1, 8'd6, 1'b0, 1'b0, 1'b0, 8'd0},
    {3'b110, 2'd2, 8'd6, 1'b0, 1'b0, 1'b0, 8'd0},
    {3'b111, 2'd3, 8'd5, 1'b0, 1'b0, 1'b0, 8'd5},
    {3'b100, 2'd0, 8'd6, 1'b1, 1'b1, 1'b1, 8'd8},
    {3'b101, 2'd0, 8'd6, 1'b0, 1'b1, 1'b0, 8'd0},
    {3'b010, 2'd0, 8'd6, 1'b0, 1'b1, 1'b0, 8'd0},
    {3'b110, 2'd0, 8'd0, 1'b1, 1'b1, 1'b0, 8'd0}
  };

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    longint p;
    int bad;
    cycles(2);
    // R10 reset state
    chk(cfg_done == 1'b0 && err_n == 1'b1 && ser_en_n == 1'b1 && coef_we == 1'b0,
        "R10 reset outputs", {cfg_done, err_n, ser_en_n, coef_we}, 4'b0110);

    for (int v = 0; v < 9; v++) begin
      {strap_par, strap_m1, strap_m0} = VEC[v][23:21];
      corrupt  = VEC[v][20:19];
      prog_len = VEC[v][18:11];
      do_reset();
      cycles(3000);
      chk(cfg_done == VEC[v][10], $sformatf("R1 R5 R6 vec%0d cfg_done", v), cfg_done, VEC[v][10]);
      chk(err_n == VEC[v][9], $sformatf("R1 R6 vec%0d err_n", v), err_n, VEC[v][9]);
      chk(wr_cnt == int'(VEC[v][7:0]), $sformatf("R4 R9 vec%0d write count", v), wr_cnt, VEC[v][7:0]);
      chk(ser_en_n == 1'b1, $sformatf("R2 vec%0d enable after load", v), ser_en_n, 1);
      bad = 0;
      for (int i = 0; i < int'(VEC[v][7:0]); i++)
        if (mem[i] != (VEC[v][8] ? r_word(i) : e_word(i))) bad++;
      chk(bad == 0, $sformatf("R3 R4 R9 vec%0d data MSB-first", v), bad, 0);
    end

    // R2 R3: EPROM load enable and serial clock rate
    {strap_par, strap_m1, strap_m0} = 3'b110; corrupt = 2'd0; prog_len = 8'd4;
    do_reset();
    cycles(3);
    chk(ser_en_n == 1'b0, "R2 enable low during load", ser_en_n, 0);
    period(p);
    chk(p == 320, "R3 load clock period ns", p, 320);
    cycles(2000);
    chk(cfg_done == 1'b1, "R5 done after eprom load", cfg_done, 1);
    // R8 run clock rates
    rate_sel = 1'b0;
    cycles(2);
    period(p);
    chk(p == 20, "R8 run clock rate_sel=0 ns", p, 20);
    rate_sel = 1'b1;
    cycles(2);
    period(p);
    chk(p == 40, "R8 run clock rate_sel=1 ns", p, 40);

    // R9: internal mode keeps enable high, slow clock during load
    {strap_par, strap_m1, strap_m0} = 3'b100; rate_sel = 1'b0;
    do_reset();
    cycles(3);
    chk(ser_en_n == 1'b1, "R9 enable high in internal mode", ser_en_n, 1);
    period(p);
    chk(p == 320, "R9 internal load clock period ns", p, 320);
    cycles(3000);
    period(p);
    chk(p == 20, "R8 internal mode run clock ns", p, 20);

    // R6 R7: checksum failure holds, reconfigure restarts
    {strap_par, strap_m1, strap_m0} = 3'b110; corrupt = 2'd3; prog_len = 8'd4;
    do_reset();
    cycles(2000);
    chk(err_n == 1'b0, "R6 checksum error flagged", err_n, 0);
    cycles(1000);
    chk(err_n == 1'b0 && cfg_done == 1'b0, "R6 error held", {err_n, cfg_done}, 0);
    corrupt = 2'd0;
    wr_cnt = 0;
    reconf_n = 1'b0;
    cycles(2);
    reconf_n = 1'b1;
    cycles(3);
    chk(ser_en_n == 1'b0, "R7 enable low again after reconfigure", ser_en_n, 0);
    chk(err_n == 1'b1, "R7 error cleared by reconfigure", err_n, 1);
    cycles(2000);
    chk(cfg_done == 1'b1 && err_n == 1'b1, "R7 reload succeeds", {cfg_done, err_n}, 2'b11);
    chk(wr_cnt == 4, "R7 reload write count", wr_cnt, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule